// File: doc/BRIEF.md
# SPI Flash Page-Program Controller

This block is the slave-side command logic of a serial NOR flash, limited to page programming. It samples chip select, serial clock and serial data in on its own system clock (SPI mode 0, inputs taken on serial clock rising edges) and decodes three commands. The commands are a write enable, a status read and a page program with a 24-bit address. Program data is collected into a one-page (256-byte) buffer. The byte pointer wraps inside the page, so the last 256 bytes received win.

When chip select rises exactly on a data byte boundary, a self-timed program cycle starts and runs for a parameterised number of system clock cycles. During the cycle the buffered bytes are ANDed into a small behavioural array, one byte per clock in ascending offset order. Per-page protection arrives as an input vector. An asynchronous reset aborts a running cycle. After reset is released, chip select is ignored for a recovery period.

The array has a combinational read port. This port is how the surrounding model (or a bench) observes the stored contents.

Top module: `spi_flash_pp_ctrl`

## Requirements
- R1: After reset, the write-enable latch and write-in-progress bits are 0 and miso_o is 0. The array holds 0xFF in every byte at power-up.
- R2: Opcode 0x06 sets the write-enable latch once its eighth bit is received. This happens even while a program cycle is running.
- R3: Opcode 0x05 returns a status byte, MSB first, with bits shifted out after serial clock falling edges. Bit 0 is write-in-progress, bit 1 is the write-enable latch, and the other bits are 0. The byte repeats, freshly sampled, for as long as chip select stays low.
- R4: Opcode 0x02 is ignored when the write-enable latch is 0, and the array stays unchanged.
- R5: A program frame carries three address bytes, MSB first, after the opcode. Address bits 9:8 select the page and bits 7:0 give the start offset. Data bytes go to consecutive offsets.
- R6: When the offset passes 0xFF, it wraps to 0x00 of the same page.
- R7: When more than 256 data bytes are sent, each offset holds the last byte sent to it.
- R8: Programming only clears bits, so each stored byte becomes old AND new. Offsets that received no data keep their contents.
- R9: The program cycle starts only if chip select rises after at least one whole data byte and on a byte boundary. Any other rise cancels the command and leaves the write-enable latch unchanged.
- R10: Once started, write-in-progress reads 1 for PROG_CYCLES clocks, and the write-enable latch is cleared when the cycle starts. Buffered bytes are written at one offset per clock, starting at offset 0.
- R11: A program command to a page whose prot_i bit is 1 is not executed, and the write-enable latch is kept.
- R12: A program command received while a cycle is running is rejected, and the running cycle completes unchanged.
- R13: Asserting rst_ni low aborts a running cycle, leaving only the bytes already written, and clears both status bits. Chip select activity that begins within RECOV_CYCLES clocks after rst_ni rises is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock (mode 0) |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out (status bytes) |
| prot_i | input | NUM_PAGES | Per-page program protection |
| rd_addr_i | input | PG_W+8 | Array read address {page, offset} |
| rd_data_o | output | 8 | Array read data |

## Verification
The assertions check several conditions on every cycle. A started cycle always finds the write-enable latch set and its page unprotected. No cycle starts while another is running. The latch is already clear when write-in-progress rises. No command takes effect during the reset recovery window. Only the bench scenarios can show the rest, because it depends on data values and on ordering across frames. That covers the AND-only array contents, the wrap and last-256-wins behaviour, and cancellation on a chip select rise that falls mid-byte. It also covers rejection while busy and the partial page left by a reset abort.

// File: rtl/spi_fp_pkg.sv
`timescale 1ns/1ps
package spi_fp_pkg;
  localparam logic [7:0] OP_WR_EN  = 8'h06;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_PROG   = 8'h02;

  typedef enum logic [2:0] {
    FR_IDLE, FR_OPC, FR_ADDR, FR_DATA, FR_STAT, FR_SKIP
  } frame_st_e;
endpackage

// File: rtl/spi_fp_sync.sv
`timescale 1ns/1ps
module spi_fp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic mosi_o
);
  logic [STAGES:0]   sck_p, cs_p;
  logic [STAGES-1:0] mosi_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[STAGES-1:0], sck_i};
      cs_p   <= {cs_p[STAGES-1:0], cs_ni};
      mosi_p <= {mosi_p[STAGES-2:0], mosi_i};
    end
  end

  // mosi aligned with the newest synchronized sck sample
  assign sck_rise_o = sck_p[STAGES-1] & ~sck_p[STAGES];
  assign sck_fall_o = ~sck_p[STAGES-1] & sck_p[STAGES];
  assign cs_fall_o  = ~cs_p[STAGES-1] & cs_p[STAGES];
  assign cs_rise_o  = cs_p[STAGES-1] & ~cs_p[STAGES];
  assign mosi_o     = mosi_p[STAGES-1];
endmodule

// File: rtl/spi_fp_frame.sv
`timescale 1ns/1ps
module spi_fp_frame
  import spi_fp_pkg::*;
#(
  parameter int PG_W       = 2,
  parameter int ADDR_BYTES = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sck_rise_i,
  input  logic            sck_fall_i,
  input  logic            cs_fall_i,
  input  logic            cs_rise_i,
  input  logic            mosi_i,
  input  logic            ready_i,
  input  logic            wel_i,
  input  logic            busy_i,
  input  logic            prot_i,
  input  logic [7:0]      status_i,
  output logic            wren_o,
  output logic            commit_o,
  output logic            clr_o,
  output logic            wr_en_o,
  output logic [7:0]      wr_off_o,
  output logic [7:0]      wr_byte_o,
  output logic [PG_W-1:0] page_o,
  output logic            miso_o
);
  localparam int AC_W = $clog2(ADDR_BYTES + 1);

  frame_st_e       state_q;
  logic [2:0]      bcnt_q;
  logic [6:0]      sh_q;
  logic [AC_W-1:0] acnt_q;
  logic [PG_W-1:0] page_q;
  logic [7:0]      off_q;
  logic            got_q;
  logic [7:0]      tx_q;

  logic       shifting, byte_done;
  logic [7:0] rx_byte;

  assign rx_byte   = {sh_q, mosi_i};
  assign shifting  = sck_rise_i &&
                     (state_q inside {FR_OPC, FR_ADDR, FR_DATA, FR_STAT});
  assign byte_done = shifting && (bcnt_q == 3'd7);

  assign wren_o    = byte_done && state_q == FR_OPC && rx_byte == OP_WR_EN;
  assign clr_o     = byte_done && state_q == FR_OPC && rx_byte == OP_PROG &&
                     wel_i && !busy_i;
  assign wr_en_o   = byte_done && state_q == FR_DATA;
  assign wr_off_o  = off_q;
  assign wr_byte_o = rx_byte;
  assign page_o    = page_q;
  // commit only on a whole-byte boundary with data present
  assign commit_o  = cs_rise_i && state_q == FR_DATA && bcnt_q == 3'd0 &&
                     got_q && !prot_i;
  assign miso_o    = (state_q == FR_STAT) && tx_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FR_IDLE;
      bcnt_q  <= '0;
      sh_q    <= '0;
      acnt_q  <= '0;
      page_q  <= '0;
      off_q   <= '0;
      got_q   <= 1'b0;
      tx_q    <= '0;
    end else if (cs_rise_i) begin
      state_q <= FR_IDLE;
    end else if (cs_fall_i) begin
      state_q <= ready_i ? FR_OPC : FR_SKIP;
      bcnt_q  <= '0;
      acnt_q  <= '0;
      got_q   <= 1'b0;
      tx_q    <= '0;
    end else begin
      if (shifting) begin
        sh_q   <= rx_byte[6:0];
        bcnt_q <= bcnt_q + 3'd1;
      end
      if (byte_done) begin
        case (state_q)
          FR_OPC: begin
            case (rx_byte)
              OP_STATUS: state_q <= FR_STAT;
              OP_PROG:   state_q <= (wel_i && !busy_i) ? FR_ADDR : FR_SKIP;
              default:   state_q <= FR_SKIP;
            endcase
          end
          FR_ADDR: begin
            acnt_q <= acnt_q + 1'b1;
            if (acnt_q == AC_W'(ADDR_BYTES - 2)) page_q <= rx_byte[PG_W-1:0];
            if (acnt_q == AC_W'(ADDR_BYTES - 1)) begin
              off_q   <= rx_byte;
              state_q <= FR_DATA;
            end
          end
          FR_DATA: begin
            off_q <= off_q + 8'd1;
            got_q <= 1'b1;
          end
          default: ;
        endcase
      end
      if (sck_fall_i && state_q == FR_STAT)
        tx_q <= (bcnt_q == 3'd0) ? status_i : {tx_q[6:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_fp_store.sv
`timescale 1ns/1ps
module spi_fp_store #(
  parameter int NUM_PAGES   = 4,
  parameter int PG_W        = 2,
  parameter int PAGE_AW     = 8,
  parameter int PROG_CYCLES = 1000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    wr_en_i,
  input  logic [PAGE_AW-1:0]      wr_off_i,
  input  logic [7:0]              wr_byte_i,
  input  logic                    start_i,
  input  logic [PG_W-1:0]         page_i,
  input  logic [PG_W+PAGE_AW-1:0] rd_addr_i,
  output logic                    busy_o,
  output logic [7:0]              rd_data_o
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int MEM_BYTES  = NUM_PAGES * PAGE_BYTES;
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1);

  logic [7:0]            pbuf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [7:0]            mem_q  [MEM_BYTES];

  logic                  busy_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [PG_W-1:0]       pg_q;
  logic [PAGE_AW-1:0]    prog_off;
  logic                  prog_we;

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) mem_q[i] = 8'hFF;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) pbuf_q[wr_off_i] <= wr_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        vld_q <= '0;
    else if (clr_i)     vld_q <= '0;
    else if (wr_en_i)   vld_q[wr_off_i] <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pg_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      pg_q   <= page_i;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(PROG_CYCLES - 1)) busy_q <= 1'b0;
    end
  end

  // one buffered byte per clock, ascending offset
  assign prog_off = cnt_q[PAGE_AW-1:0];
  assign prog_we  = busy_q && (cnt_q < CNT_W'(PAGE_BYTES)) && vld_q[prog_off];

  always_ff @(posedge clk_i) begin
    if (prog_we) mem_q[{pg_q, prog_off}] <= mem_q[{pg_q, prog_off}] & pbuf_q[prog_off];
  end

  assign busy_o    = busy_q;
  assign rd_data_o = mem_q[rd_addr_i];

  p_no_restart_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/spi_flash_pp_ctrl.sv
`timescale 1ns/1ps
module spi_flash_pp_ctrl #(
  parameter int NUM_PAGES    = 4,
  parameter int PROG_CYCLES  = 1000,
  parameter int RECOV_CYCLES = 64,
  parameter int SYNC_STAGES  = 2,
  localparam int PG_W        = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int MEM_AW      = PG_W + 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sck_i,
  input  logic                 cs_ni,
  input  logic                 mosi_i,
  output logic                 miso_o,
  input  logic [NUM_PAGES-1:0] prot_i,
  input  logic [MEM_AW-1:0]    rd_addr_i,
  output logic [7:0]           rd_data_o
);
  localparam int RC_W = $clog2(RECOV_CYCLES + 1);

  logic sck_rise, sck_fall, cs_fall, cs_rise, mosi_s;
  logic wren, commit, clr, wr_en, busy, ready, prot_sel;
  logic [7:0] wr_off, wr_byte, status;
  logic [PG_W-1:0] page;
  logic wel_q;
  logic [RC_W-1:0] rc_q;

  spi_fp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .mosi_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise), .mosi_o(mosi_s)
  );

  assign prot_sel = prot_i[page];
  assign status   = {6'b0, wel_q, busy};
  assign ready    = (rc_q == '0);

  spi_fp_frame #(.PG_W(PG_W), .ADDR_BYTES(3)) u_frame (
    .clk_i, .rst_ni,
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .mosi_i(mosi_s),
    .ready_i(ready), .wel_i(wel_q), .busy_i(busy), .prot_i(prot_sel),
    .status_i(status),
    .wren_o(wren), .commit_o(commit), .clr_o(clr), .wr_en_o(wr_en),
    .wr_off_o(wr_off), .wr_byte_o(wr_byte), .page_o(page), .miso_o(miso_o)
  );

  spi_fp_store #(
    .NUM_PAGES(NUM_PAGES), .PG_W(PG_W), .PAGE_AW(8), .PROG_CYCLES(PROG_CYCLES)
  ) u_store (
    .clk_i, .rst_ni, .clr_i(clr), .wr_en_i(wr_en), .wr_off_i(wr_off),
    .wr_byte_i(wr_byte), .start_i(commit), .page_i(page),
    .rd_addr_i(rd_addr_i), .busy_o(busy), .rd_data_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wel_q <= 1'b0;
    else if (commit) wel_q <= 1'b0;
    else if (wren)   wel_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rc_q <= RC_W'(RECOV_CYCLES);
    else if (rc_q != '0)  rc_q <= rc_q - 1'b1;
  end

  p_commit_wel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> wel_q);
  p_wel_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !wel_q);
  p_commit_prot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> !prot_i[page]);
  p_recov_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> (!wren && !commit && !clr));
endmodule

// File: tb/test_spi_flash_pp_ctrl.sv
`timescale 1ns/1ps
module test_spi_flash_pp_ctrl;
  localparam int NP    = 4;
  localparam int PROGC = 1000;
  localparam int RECOV = 64;
  localparam int HALF  = 48;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [NP-1:0] prot = '0;
  logic [9:0] rd_addr = '0;
  logic [7:0] rd_data;

  int nchk = 0, nerr = 0;
  logic [7:0] model [1024];
  logic [7:0] dat [300];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_phase = 1'b0;
  logic [7:0] rx = '0;
  int         rx_n = 0;

  always #4 clk = ~clk;

  spi_flash_pp_ctrl #(.NUM_PAGES(NP), .PROG_CYCLES(PROGC), .RECOV_CYCLES(RECOV))
  i_spi_flash_pp_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .prot_i(prot), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: assemble status bytes and pop expectations
  always @(posedge sck) begin
    if (rd_phase) begin
      rx = {rx[6:0], miso};
      rx_n++;
      if (rx_n == 8) begin
        rx_n = 0;
        if (exp_q.size() == 0) check("R3 unexpected byte", rx, 8'hxx);
        else check(tag_q.pop_front(), rx, exp_q.pop_front());
      end
    end
  end

  task automatic send_bits(input logic [7:0] b, input int k);
    for (int i = 7; i > 7 - k; i--) begin
      mosi = b[i];
      #HALF sck = 1'b1;
      #HALF sck = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    #HALF;
  endtask

  task automatic cs_end();
    #HALF cs_n = 1'b1;
    #(4 * HALF);
  endtask

  task automatic wren();
    cs_begin(); send_byte(8'h06); cs_end();
  endtask

  task automatic rdsr(input logic [7:0] e, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    cs_begin();
    send_byte(8'h05);
    rx_n = 0;
    rd_phase = 1'b1;
    for (int i = 0; i < n; i++) send_byte(8'h00);
    rd_phase = 1'b0;
    cs_end();
  endtask

  task automatic pp(input int pg, input logic [7:0] off, input int n, input bit commit);
    logic [7:0] fin [256];
    bit         has [256];
    cs_begin();
    send_byte(8'h02);
    send_byte(8'h00);
    send_byte(8'(pg));
    send_byte(off);
    for (int i = 0; i < n; i++) send_byte(dat[i]);
    cs_end();
    if (commit) begin
      for (int i = 0; i < 256; i++) has[i] = 1'b0;
      for (int i = 0; i < n; i++) begin
        fin[(int'(off) + i) % 256] = dat[i];
        has[(int'(off) + i) % 256] = 1'b1;
      end
      for (int i = 0; i < 256; i++)
        if (has[i]) model[pg * 256 + i] = model[pg * 256 + i] & fin[i];
    end
  endtask

  task automatic chk_mem(input int a, input string tag);
    @(negedge clk) rd_addr = 10'(a);
    #1 check(tag, rd_data, model[a]);
  endtask

  task automatic wait_prog();
    repeat (PROGC + 10) @(posedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = 8'hFF;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk) check("R1 miso after reset", {7'b0, miso}, 8'h00);
    repeat (RECOV + 10) @(posedge clk);
    chk_mem(0, "R1 erased"); chk_mem(517, "R1 erased"); chk_mem(1023, "R1 erased");
    rdsr(8'h00, 1, "R1 status after reset");

    // R4: program without write enable
    dat[0] = 8'hA5;
    pp(0, 8'h10, 1, 1'b0);
    wait_prog();
    rdsr(8'h00, 1, "R4 no cycle without latch");
    chk_mem(16'h010, "R4 array unchanged");

    // R2/R3: latch set, status repeats
    wren();
    rdsr(8'h02, 2, "R2 R3 latch set repeated status");

    // R5/R10: basic program
    dat[0] = 8'hA5; dat[1] = 8'h3C; dat[2] = 8'hF0;
    pp(0, 8'h10, 3, 1'b1);
    rdsr(8'h01, 1, "R10 busy latch cleared");
    wait_prog();
    rdsr(8'h00, 1, "R10 cycle finished");
    chk_mem(16'h00F, "R8 neighbour below");
    chk_mem(16'h010, "R5 byte0"); chk_mem(16'h011, "R5 byte1");
    chk_mem(16'h012, "R5 byte2"); chk_mem(16'h013, "R8 neighbour above");

    // R8: AND-only
    wren();
    dat[0] = 8'h5A;
    pp(0, 8'h10, 1, 1'b1);
    wait_prog();
    chk_mem(16'h010, "R8 and result");

    // R6: wrap in page 1
    wren();
    dat[0] = 8'h11; dat[1] = 8'h22; dat[2] = 8'h33; dat[3] = 8'h44;
    pp(1, 8'hFE, 4, 1'b1);
    wait_prog();
    chk_mem(16'h1FE, "R6 pre-wrap"); chk_mem(16'h1FF, "R6 last offset");
    chk_mem(16'h100, "R6 wrapped 0"); chk_mem(16'h101, "R6 wrapped 1");
    chk_mem(16'h102, "R8 untouched after wrap");

    // R7: 260 bytes to page 2
    wren();
    for (int i = 0; i < 260; i++) dat[i] = 8'(i) ^ 8'hC3 ^ 8'((i / 256) * 8'h5C);
    pp(2, 8'h00, 260, 1'b1);
    wait_prog();
    for (int i = 0; i < 6; i++) chk_mem(16'h200 + i, "R7 last bytes win");
    chk_mem(16'h2FF, "R7 tail byte");

    // R9: cancelled frames
    wren();
    cs_begin();
    send_byte(8'h02); send_byte(8'h00); send_byte(8'h03); send_byte(8'h20);
    send_byte(8'h00); send_bits(8'h00, 4);
    cs_end();
    rdsr(8'h02, 1, "R9 mid-byte rise cancels");
    chk_mem(16'h320, "R9 array unchanged");
    cs_begin();
    send_byte(8'h02); send_byte(8'h00); send_byte(8'h03); send_byte(8'h20);
    cs_end();
    rdsr(8'h02, 1, "R9 no data cancels");

    // R11: protected page
    prot = 4'b1000;
    dat[0] = 8'h00;
    pp(3, 8'h40, 1, 1'b0);
    rdsr(8'h02, 1, "R11 protected not run");
    chk_mem(16'h340, "R11 array unchanged");
    prot = '0;

    // R12: program while busy
    dat[0] = 8'h0F;
    pp(3, 8'h50, 1, 1'b1);
    wren();
    dat[0] = 8'h00;
    pp(3, 8'h51, 1, 1'b0);
    rdsr(8'h03, 1, "R2 R12 latch set during busy");
    wait_prog();
    chk_mem(16'h350, "R12 running cycle intact");
    chk_mem(16'h351, "R12 rejected program");
    rdsr(8'h02, 1, "R12 latch kept after reject");

    // R13: reset abort and recovery
    for (int i = 0; i < 4; i++) dat[i] = 8'h00;
    pp(1, 8'hFE, 4, 1'b0);
    repeat (30) @(posedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    model[16'h100] = 8'h00; model[16'h101] = 8'h00;
    wren();
    repeat (RECOV) @(posedge clk);
    rdsr(8'h00, 1, "R13 status cleared and frame ignored");
    chk_mem(16'h100, "R10 R13 early offset written");
    chk_mem(16'h101, "R10 R13 early offset written");
    chk_mem(16'h1FE, "R10 R13 late offset not reached");
    chk_mem(16'h1FF, "R10 R13 late offset not reached");
    wren();
    rdsr(8'h02, 1, "R13 commands work after recovery");

    check("R3 all status bytes seen", 8'(exp_q.size()), 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule